// File: doc/BRIEF.md
# Condition Flag Update Unit

This block works out the condition flag byte of an 8-bit accumulator datapath after one instruction. A caller presents an operation code, the accumulator value, a second operand, a 16-bit register pair and the present flag byte, and raises a request for one cycle. The unit latches these values and steps through a short sequence. It then returns the new flag byte, the new accumulator value and the new register pair value, and marks them with a one-cycle result pulse.

Each instruction class has a mask. The mask decides, for each of the five flags, whether the old value is kept, a new value is computed, or the flag is forced to zero. Some flags therefore do not follow the result. Compare computes every flag from a subtraction but leaves the accumulator as it was. Logical OR and XOR compute sign, zero and parity, and clear the two carry flags. Move, halt and the register pair decrement leave the whole flag byte untouched.

The sequencer has three named states. ST_IDLE waits for a request. The transition ACCEPT (ST_IDLE to ST_EXEC) latches the inputs. The transition COMMIT (ST_EXEC to ST_DONE) loads the output registers. The transition RELEASE (ST_DONE to ST_IDLE) ends the pulse.

Top module: `flagu_top`

## Requirements
- R1: A request (`op_valid`=1) sampled in ST_IDLE is accepted. `res_valid` is 1 for exactly one cycle, after the second rising edge following acceptance. A request sampled in ST_EXEC or ST_DONE is ignored.
- R2: Operation codes 0 (move), 5 (halt) and the unused codes 6 and 7 leave the flag byte unchanged. Move puts the operand in the accumulator. Halt and the unused codes leave the accumulator unchanged. None of these codes changes the register pair.
- R3: Code 1 (OR) gives accumulator = A OR B and computes S, Z and P from that result. It forces AC=0 and CY=0.
- R4: Code 2 (XOR) gives accumulator = A XOR B and computes S, Z and P from that result. It forces AC=0 and CY=0. XOR of a value with itself gives Z=1, P=1 and S=0.
- R5: Code 3 (compare) computes the difference D = A - B, which is not written to the accumulator. It sets S = bit 7 of D, Z=1 when A equals B, CY=1 when B is greater than A (unsigned), and AC=1 when the low nibble of B is greater than the low nibble of A. P is computed from D.
- R6: Code 4 (pair decrement) gives pair = pair - 1 and wraps 0x0000 to 0xFFFF. It leaves the flag byte and the accumulator unchanged.
- R7: The flag byte places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 are copied from `flags_in` for every code.
- R8: P is 1 when the value it is computed from has an even number of 1 bits.
- R9: After reset all outputs are zero and `res_valid` is 0. The outputs hold their values between result pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Request strobe |
| op_code | input | 3 | Instruction class code |
| acc_in | input | 8 | Accumulator value A |
| opnd_in | input | 8 | Second operand B |
| pair_in | input | 16 | Register pair value |
| flags_in | input | 8 | Present flag byte |
| res_valid | output | 1 | One-cycle result pulse |
| flags_out | output | 8 | Next flag byte |
| acc_out | output | 8 | Next accumulator value |
| pair_out | output | 16 | Next register pair value |

## Verification
The assertions compare the outputs at each result pulse with the unit's own latched copies of the request. They therefore assume that the inputs matter only in the cycle a request is accepted, and that the caller may change them freely afterwards. The bench makes use of this assumption: it changes the operand inputs while the unit is busy. It also holds the strobe high through ST_EXEC and ST_DONE with a different request, to show that such a request has no effect. Every request is issued from ST_IDLE and is left to finish before the next one, so each pulse belongs to exactly one known request.

// File: rtl/flagu_pkg.sv
package flagu_pkg;

    localparam int FLAG_N = 5;

    // Instruction class codes
    localparam logic [2:0] OP_MOVE = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_XOR  = 3'd2;
    localparam logic [2:0] OP_CMP  = 3'd3;
    localparam logic [2:0] OP_DECP = 3'd4;
    localparam logic [2:0] OP_HALT = 3'd5;

    // Index of each flag inside the five-entry mask vectors
    localparam int FI_CY = 0;
    localparam int FI_P  = 1;
    localparam int FI_AC = 2;
    localparam int FI_Z  = 3;
    localparam int FI_S  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        logic [FLAG_N-1:0] keep;
        logic [FLAG_N-1:0] calc;
    } fmask_t;

    // Position of each flag inside the flag byte
    function automatic int fpos(input int idx);
        case (idx)
            FI_CY:   fpos = 0;
            FI_P:    fpos = 2;
            FI_AC:   fpos = 4;
            FI_Z:    fpos = 6;
            default: fpos = 7;
        endcase
    endfunction

    // Mask for each instruction class: keep old, compute new, or clear
    function automatic fmask_t mask_of(input logic [2:0] op);
        fmask_t m;
        m.keep = '1;
        m.calc = '0;
        case (op)
            OP_OR, OP_XOR: begin
                m.keep = '0;
                m.calc = '0;
                m.calc[FI_S] = 1'b1;
                m.calc[FI_Z] = 1'b1;
                m.calc[FI_P] = 1'b1;
            end
            OP_CMP: begin
                m.keep = '0;
                m.calc = '1;
            end
            default: begin
                m.keep = '1;
                m.calc = '0;
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/flagu_ctrl.sv
module flagu_ctrl
    import flagu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    output logic accept,
    output logic commit,
    output logic res_valid
);

    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: ACCEPT, COMMIT, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (op_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = (state_q == ST_IDLE) && op_valid;
        commit    = (state_q == ST_EXEC);
        res_valid = (state_q == ST_DONE);
    end

endmodule

// File: rtl/flagu_alu.sv
module flagu_alu
    import flagu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [PAIR_W-1:0] pair,
    output logic [DATA_W-1:0] acc_res,
    output logic [PAIR_W-1:0] pair_res,
    output logic [DATA_W-1:0] flag_src,
    output logic              cy_raw,
    output logic              ac_raw
);

    localparam int NIB_W = DATA_W / 2;
    localparam logic [PAIR_W-1:0] PAIR_ONE = PAIR_W'(1);

    logic [DATA_W:0] diff_w;
    logic [NIB_W:0]  half_w;

    assign diff_w = {1'b0, a} - {1'b0, b};
    assign half_w = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
    assign cy_raw = diff_w[DATA_W];
    assign ac_raw = half_w[NIB_W];

    always_comb begin
        acc_res  = a;
        pair_res = pair;
        flag_src = a;
        case (op)
            OP_MOVE: acc_res = b;
            OP_OR: begin
                acc_res  = a | b;
                flag_src = a | b;
            end
            OP_XOR: begin
                acc_res  = a ^ b;
                flag_src = a ^ b;
            end
            OP_CMP:  flag_src = diff_w[DATA_W-1:0];
            OP_DECP: pair_res = pair - PAIR_ONE;
            default: ;
        endcase
    end

endmodule

// File: rtl/flagu_flags.sv
module flagu_flags
    import flagu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [7:0]        flags_in,
    input  logic [DATA_W-1:0] flag_src,
    input  logic              cy_raw,
    input  logic              ac_raw,
    output logic [7:0]        flags_nxt
);

    fmask_t            msk;
    logic [FLAG_N-1:0] calc_v;
    logic [FLAG_N-1:0] new_bit;

    assign msk = mask_of(op);

    always_comb begin
        calc_v        = '0;
        calc_v[FI_CY] = cy_raw;
        calc_v[FI_P]  = ~(^flag_src);
        calc_v[FI_AC] = ac_raw;
        calc_v[FI_Z]  = (flag_src == '0);
        calc_v[FI_S]  = flag_src[DATA_W-1];
    end

    genvar gi;
    generate
        for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
            assign new_bit[gi] = msk.keep[gi] ? flags_in[fpos(gi)]
                                              : (msk.calc[gi] & calc_v[gi]);
        end
    endgenerate

    always_comb begin
        flags_nxt = flags_in;
        for (int i = 0; i < FLAG_N; i++) begin
            flags_nxt[fpos(i)] = new_bit[i];
        end
    end

endmodule

// File: rtl/flagu_top.sv
module flagu_top
    import flagu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [PAIR_W-1:0] pair_in,
    input  logic [7:0]        flags_in,
    output logic              res_valid,
    output logic [7:0]        flags_out,
    output logic [DATA_W-1:0] acc_out,
    output logic [PAIR_W-1:0] pair_out
);

    logic              accept;
    logic              commit;
    logic [2:0]        cap_op;
    logic [DATA_W-1:0] cap_acc;
    logic [DATA_W-1:0] cap_opnd;
    logic [PAIR_W-1:0] cap_pair;
    logic [7:0]        cap_flags;
    logic [DATA_W-1:0] acc_res;
    logic [PAIR_W-1:0] pair_res;
    logic [DATA_W-1:0] flag_src;
    logic              cy_raw;
    logic              ac_raw;
    logic [7:0]        flags_nxt;

    flagu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .accept    (accept),
        .commit    (commit),
        .res_valid (res_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_op    <= OP_MOVE;
            cap_acc   <= '0;
            cap_opnd  <= '0;
            cap_pair  <= '0;
            cap_flags <= '0;
        end else if (accept) begin
            cap_op    <= op_code;
            cap_acc   <= acc_in;
            cap_opnd  <= opnd_in;
            cap_pair  <= pair_in;
            cap_flags <= flags_in;
        end
    end

    flagu_alu #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_alu (
        .op       (cap_op),
        .a        (cap_acc),
        .b        (cap_opnd),
        .pair     (cap_pair),
        .acc_res  (acc_res),
        .pair_res (pair_res),
        .flag_src (flag_src),
        .cy_raw   (cy_raw),
        .ac_raw   (ac_raw)
    );

    flagu_flags #(.DATA_W(DATA_W)) u_flags (
        .op        (cap_op),
        .flags_in  (cap_flags),
        .flag_src  (flag_src),
        .cy_raw    (cy_raw),
        .ac_raw    (ac_raw),
        .flags_nxt (flags_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_out <= '0;
            acc_out   <= '0;
            pair_out  <= '0;
        end else if (commit) begin
            flags_out <= flags_nxt;
            acc_out   <= acc_res;
            pair_out  <= pair_res;
        end
    end

endmodule

// File: rtl/flagu_chk.sv
module flagu_chk
    import flagu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PAIR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [7:0]        flags_out,
    input logic [DATA_W-1:0] acc_out,
    input logic [PAIR_W-1:0] pair_out,
    input logic [2:0]        cap_op,
    input logic [DATA_W-1:0] cap_acc,
    input logic [DATA_W-1:0] cap_opnd,
    input logic [PAIR_W-1:0] cap_pair,
    input logic [7:0]        cap_flags
);

    p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_keep_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (cap_op == OP_MOVE || cap_op == OP_HALT || cap_op == OP_DECP))
        |-> (flags_out == cap_flags));

    p_logic_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (cap_op == OP_OR || cap_op == OP_XOR))
        |-> (flags_out[4] == 1'b0 && flags_out[0] == 1'b0));

    p_self_xor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_op == OP_XOR && cap_acc == cap_opnd)
        |-> (flags_out[6] && flags_out[2] && !flags_out[7]));

    p_cmp_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_op == OP_CMP)
        |-> (acc_out == cap_acc && flags_out[6] == (cap_acc == cap_opnd)
             && flags_out[0] == (cap_opnd > cap_acc)));

    p_pair_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && cap_op == OP_DECP)
        |-> (pair_out == cap_pair - PAIR_W'(1)));

    p_spare_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (flags_out[5] == cap_flags[5] && flags_out[3] == cap_flags[3]
                       && flags_out[1] == cap_flags[1]));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(flags_out) && $stable(acc_out) && $stable(pair_out)));

endmodule

bind flagu_top flagu_chk #(.DATA_W(DATA_W), .PAIR_W(PAIR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .flags_out (flags_out),
    .acc_out   (acc_out),
    .pair_out  (pair_out),
    .cap_op    (cap_op),
    .cap_acc   (cap_acc),
    .cap_opnd  (cap_opnd),
    .cap_pair  (cap_pair),
    .cap_flags (cap_flags)
);

// File: tb/flagu_top_tb.sv
`timescale 1ns/1ps
module flagu_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [7:0]  acc_in = 8'h00;
    logic [7:0]  opnd_in = 8'h00;
    logic [15:0] pair_in = 16'h0000;
    logic [7:0]  flags_in = 8'h00;
    logic        res_valid;
    logic [7:0]  flags_out;
    logic [7:0]  acc_out;
    logic [15:0] pair_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    flagu_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .pair_in   (pair_in),
        .flags_in  (flags_in),
        .res_valid (res_valid),
        .flags_out (flags_out),
        .acc_out   (acc_out),
        .pair_out  (pair_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic even_par(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += v[i];
        return (n % 2) == 0;
    endfunction

    // Reference flag byte built from the requirements
    function automatic logic [7:0] ref_flags(input logic [2:0] op, input logic [7:0] a,
                                             input logic [7:0] b, input logic [7:0] f);
        logic [7:0] r = f;
        logic [7:0] v;
        int d;
        case (op)
            3'd1, 3'd2: begin
                v = (op == 3'd1) ? (a | b) : (a ^ b);
                r[7] = v[7]; r[6] = (v == 8'h00); r[2] = even_par(v);
                r[4] = 1'b0; r[0] = 1'b0;
            end
            3'd3: begin
                d = int'(a) - int'(b);
                v = d[7:0];
                r[7] = v[7]; r[6] = (a == b); r[2] = even_par(v);
                r[4] = (b[3:0] > a[3:0]); r[0] = (b > a);
            end
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ref_acc(input logic [2:0] op, input logic [7:0] a,
                                           input logic [7:0] b);
        case (op)
            3'd0: return b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            default: return a;
        endcase
    endfunction

    // Issue one request from idle and check the result pulse and values
    task automatic run_op(input string req, input logic [2:0] op, input logic [7:0] a,
                          input logic [7:0] b, input logic [15:0] p, input logic [7:0] f);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; acc_in = a; opnd_in = b; pair_in = p; flags_in = f;
        @(negedge clk);
        op_valid = 1'b0; acc_in = ~a; opnd_in = ~b; flags_in = ~f;
        chk("R1", "res_valid in exec", {31'd0, res_valid}, 32'd0);
        @(negedge clk);
        chk("R1", "res_valid pulse", {31'd0, res_valid}, 32'd1);
        chk(req, "flags", {24'd0, flags_out}, {24'd0, ref_flags(op, a, b, f)});
        chk(req, "acc", {24'd0, acc_out}, {24'd0, ref_acc(op, a, b)});
        chk(req, "pair", {16'd0, pair_out},
            {16'd0, (op == 3'd4) ? (p - 16'd1) : p});
        @(negedge clk);
        chk("R1", "res_valid after pulse", {31'd0, res_valid}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R9", "reset res_valid", {31'd0, res_valid}, 32'd0);
        chk("R9", "reset flags", {24'd0, flags_out}, 32'd0);
        chk("R9", "reset acc", {24'd0, acc_out}, 32'd0);
        chk("R9", "reset pair", {16'd0, pair_out}, 32'd0);
    endtask

    task automatic t_keep();
        run_op("R2", 3'd0, 8'h12, 8'hA5, 16'h1234, 8'hD5);
        run_op("R2", 3'd5, 8'h77, 8'h00, 16'hBEEF, 8'h2A);
        run_op("R2", 3'd6, 8'h3C, 8'hFF, 16'h0F0F, 8'hFF);
        run_op("R2", 3'd7, 8'h01, 8'h02, 16'h0001, 8'h55);
    endtask

    task automatic t_or();
        run_op("R3", 3'd1, 8'h00, 8'h00, 16'h0000, 8'hFF);
        run_op("R3", 3'd1, 8'h80, 8'h01, 16'h0000, 8'h11);
        run_op("R8", 3'd1, 8'h07, 8'h00, 16'h0000, 8'h00);
    endtask

    task automatic t_xor();
        run_op("R4", 3'd2, 8'h5A, 8'h5A, 16'h4444, 8'hFF);
        chk("R4", "self xor Z P S", {29'd0, flags_out[6], flags_out[2], flags_out[7]}, 32'd6);
        run_op("R4", 3'd2, 8'hF0, 8'h0E, 16'h0000, 8'h00);
    endtask

    task automatic t_cmp();
        run_op("R5", 3'd3, 8'h42, 8'h42, 16'h0000, 8'h00);
        run_op("R5", 3'd3, 8'h10, 8'h20, 16'h0000, 8'hFF);
        run_op("R5", 3'd3, 8'h31, 8'h0F, 16'h0000, 8'h00);
        run_op("R5", 3'd3, 8'hF0, 8'h01, 16'h0000, 8'h2A);
    endtask

    task automatic t_decp();
        run_op("R6", 3'd4, 8'h99, 8'h11, 16'h1000, 8'hC5);
        run_op("R6", 3'd4, 8'h00, 8'h00, 16'h0000, 8'h00);
        chk("R6", "wrap value", {16'd0, pair_out}, 32'h0000FFFF);
    endtask

    // A request held high while busy has no effect
    task automatic t_busy();
        logic [7:0] f_exp;
        f_exp = ref_flags(3'd1, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        op_valid = 1'b1; op_code = 3'd1; acc_in = 8'h00; opnd_in = 8'h00;
        pair_in = 16'h2222; flags_in = 8'h00;
        @(negedge clk);
        op_code = 3'd0; opnd_in = 8'hEE; flags_in = 8'hFF; pair_in = 16'h7777;
        @(negedge clk);
        chk("R1", "busy pulse", {31'd0, res_valid}, 32'd1);
        @(negedge clk);
        op_valid = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk("R1", "no second pulse", {31'd0, res_valid}, 32'd0);
            @(negedge clk);
        end
        chk("R9", "hold flags", {24'd0, flags_out}, {24'd0, f_exp});
        chk("R9", "hold acc", {24'd0, acc_out}, 32'd0);
        chk("R9", "hold pair", {16'd0, pair_out}, 32'h2222);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_keep();
        t_or();
        t_xor();
        t_cmp();
        t_decp();
        t_busy();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule